// File: doc/BRIEF.md
# Split Arrive-Wait Transaction Barrier

This block holds a small set of synchronization barrier slots that separate signalling from waiting. Producers announce that they have finished their share of work through a fire-and-forget arrival port. Asynchronous writers report how many bytes they have deposited through a separate byte-report port. A slot completes only when its arrival tally and its byte tally both exactly reach the targets loaded at initialization. On completion the slot's phase bit flips and both tallies restart, so the same slot can be used for the next round without being loaded again.

Consumers issue a wait that names a waiter index, a slot and the phase they are waiting to see finish. If that phase has already finished, the waiter's wake bit rises in the same cycle. Otherwise the waiter is parked, and the block pulses its wake bit once the slot completes, so no consumer has to poll the barrier. A byte report that would overshoot the expected total raises a sticky per-slot error and blocks completion until the slot is initialized again.

Top module: `txn_barrier`

## Requirements
- R1: After reset every slot phase bit is 0, every error flag is 0 and every wake bit is 0.
- R2: Arrivals presented on back-to-back cycles are each counted; the arrival port has no stall or ready signal.
- R3: An init on a slot loads its expected arrival count and expected byte total and discards any arrivals and bytes gathered before it.
- R4: A slot completes only when its arrival tally equals the expected count and its byte tally equals the expected total; either one alone leaves the phase unchanged.
- R5: Completion toggles `phase_o` of that slot in the cycle after the completing input, and the tallies restart so the same targets apply to the next round.
- R6: A wait whose phase value differs from the slot's current phase sets `wake_o` bit `wait_id` in the same cycle (bit i belongs to waiter i).
- R7: A wait whose phase value equals the slot's current phase keeps its wake bit low until the slot completes, then pulses it for one cycle, in the same cycle that `phase_o` flips.
- R8: A byte report that would take the byte tally above the expected total sets `err_o` for that slot; the slot then does not complete and the flag stays set until the next init, which clears it.
- R9: An arrival and a byte report to the same slot in the same cycle are both counted in that cycle.
- R10: Arrivals, byte reports and inits aimed at one slot leave the phase and error flag of every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_valid | input | 1 | Load targets into a slot |
| init_slot | input | SLOT_W | Slot to initialize |
| init_arrivals | input | CNT_W | Expected number of arrivals |
| init_bytes | input | BYTE_W | Expected byte total |
| arv_valid | input | 1 | One producer arrival |
| arv_slot | input | SLOT_W | Slot the arrival targets |
| txb_valid | input | 1 | Byte report strobe |
| txb_slot | input | SLOT_W | Slot the byte report targets |
| txb_bytes | input | BYTE_W | Bytes written by the asynchronous writer |
| wait_valid | input | 1 | Wait request |
| wait_id | input | WID_W | Index of the waiting consumer |
| wait_slot | input | SLOT_W | Slot waited on |
| wait_phase | input | 1 | Phase whose completion is awaited |
| wake_o | output | NUM_WAITERS | Per-waiter wake signal |
| phase_o | output | NUM_SLOTS | Current phase bit of each slot |
| err_o | output | NUM_SLOTS | Sticky byte-overshoot flag of each slot |

## Verification
The table-driven part tries each slot with exact matches, with arrivals short and bytes exact, with bytes short and arrivals exact, with a byte overshoot, and with a zero byte target, so that a design that completes on one tally alone, on a sum greater than or equal to the target, or on the wrong slot gives a different phase or error result. Streams overlap arrivals and byte reports in the same cycles, which separates a design that drops one of two simultaneous updates. Directed sequences contrast a wait on an already finished phase, which must wake in its own cycle, with a wait on a pending phase, which must stay low and then pulse exactly when the phase flips, and re-initialize a slot midway and after an error.

// File: rtl/txb_pkg.sv
package txb_pkg;
    localparam int DEF_SLOTS   = 4;
    localparam int DEF_WAITERS = 4;
    localparam int DEF_CNT_W   = 8;
    localparam int DEF_BYTE_W  = 16;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/txb_slot.sv
module txb_slot #(
    parameter int CNT_W  = 8,
    parameter int BYTE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_hit,
    input  logic [CNT_W-1:0]  init_arr,
    input  logic [BYTE_W-1:0] init_bytes,
    input  logic              arv_hit,
    input  logic              txb_hit,
    input  logic [BYTE_W-1:0] txb_bytes,
    output logic              phase_o,
    output logic              phase_nx_o,
    output logic              err_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  exp_arr;
        logic [CNT_W-1:0]  arr;
        logic [BYTE_W-1:0] exp_b;
        logic [BYTE_W-1:0] bcnt;
        logic              phase;
        logic              err;
    } slot_t;

    slot_t s_q, s_d;
    logic [CNT_W:0]  asum;
    logic [BYTE_W:0] bsum;
    logic            over;

    always_comb begin
        s_d  = s_q;
        asum = {1'b0, s_q.arr} + {{CNT_W{1'b0}}, arv_hit};
        bsum = {1'b0, s_q.bcnt} + (txb_hit ? {1'b0, txb_bytes} : '0);
        over = txb_hit && (bsum > {1'b0, s_q.exp_b});
        if (init_hit) begin
            s_d.exp_arr = init_arr;
            s_d.exp_b   = init_bytes;
            s_d.arr     = '0;
            s_d.bcnt    = '0;
            s_d.err     = 1'b0;
        end else begin
            s_d.arr = asum[CNT_W-1:0];
            if (over) s_d.err  = 1'b1;
            else      s_d.bcnt = bsum[BYTE_W-1:0];
            if ((arv_hit || txb_hit) && !s_q.err && !over &&
                asum == {1'b0, s_q.exp_arr} && bsum == {1'b0, s_q.exp_b}) begin
                s_d.phase = ~s_q.phase;
                s_d.arr   = '0;
                s_d.bcnt  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase_o    = s_q.phase;
    assign phase_nx_o = s_d.phase;
    assign err_o      = s_q.err;

    // R4: with no arrival and no byte report the phase cannot move
    a_r4_idle_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (!arv_hit && !txb_hit) |=> $stable(phase_o));
    // R8: a flagged slot holds its phase and its flag until re-initialized
    a_r8_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !init_hit) |=> ($stable(phase_o) && err_o));
    // R3: init leaves the slot with a clear error flag
    a_r3_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init_hit |=> !err_o);
endmodule

// File: rtl/txb_waiters.sv
module txb_waiters #(
    parameter int NW    = 4,
    parameter int NS    = 4,
    parameter int SW    = 2,
    parameter int WID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_valid,
    input  logic [WID_W-1:0] wait_id,
    input  logic [SW-1:0]    wait_slot,
    input  logic             wait_phase,
    input  logic [NS-1:0]    phase_q,
    input  logic [NS-1:0]    phase_d,
    output logic [NW-1:0]    wake_o
);
    typedef struct packed {
        logic [NW-1:0]         sleep;
        logic [NW-1:0]         ph;
        logic [NW-1:0][SW-1:0] slot;
        logic [NW-1:0]         wake;
    } wt_t;

    wt_t w_q, w_d;
    logic [NW-1:0] imm;

    always_comb begin
        w_d      = w_q;
        w_d.wake = '0;
        imm      = '0;
        for (int i = 0; i < NW; i++) begin
            if (w_q.sleep[i] && (phase_d[w_q.slot[i]] != w_q.ph[i])) begin
                w_d.sleep[i] = 1'b0;
                w_d.wake[i]  = 1'b1;
            end
        end
        if (wait_valid) begin
            if (phase_q[wait_slot] != wait_phase) begin
                imm[wait_id]       = 1'b1;
                w_d.sleep[wait_id] = 1'b0;
            end else if (phase_d[wait_slot] != wait_phase) begin
                w_d.sleep[wait_id] = 1'b0;
                w_d.wake[wait_id]  = 1'b1;
            end else begin
                w_d.sleep[wait_id] = 1'b1;
                w_d.wake[wait_id]  = 1'b0;
                w_d.slot[wait_id]  = wait_slot;
                w_d.ph[wait_id]    = wait_phase;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign wake_o = w_q.wake | imm;

    // R6: only the single requesting waiter can be woken immediately
    a_r6_one_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(imm));
    // R6: no immediate wake without a wait request
    a_r6_imm_needs_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_valid |-> (imm == '0));

    for (genvar g = 0; g < NW; g++) begin : g_chk
        // R7: a registered wake follows a parked waiter or a wait request
        a_r7_wake_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
            w_q.wake[g] |-> ($past(w_q.sleep[g]) || $past(wait_valid)));
    end
endmodule

// File: rtl/txn_barrier.sv
module txn_barrier
    import txb_pkg::*;
#(
    parameter int NUM_SLOTS   = DEF_SLOTS,
    parameter int NUM_WAITERS = DEF_WAITERS,
    parameter int CNT_W       = DEF_CNT_W,
    parameter int BYTE_W      = DEF_BYTE_W,
    localparam int SLOT_W     = idx_width(NUM_SLOTS),
    localparam int WID_W      = idx_width(NUM_WAITERS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   init_valid,
    input  logic [SLOT_W-1:0]      init_slot,
    input  logic [CNT_W-1:0]       init_arrivals,
    input  logic [BYTE_W-1:0]      init_bytes,
    input  logic                   arv_valid,
    input  logic [SLOT_W-1:0]      arv_slot,
    input  logic                   txb_valid,
    input  logic [SLOT_W-1:0]      txb_slot,
    input  logic [BYTE_W-1:0]      txb_bytes,
    input  logic                   wait_valid,
    input  logic [WID_W-1:0]       wait_id,
    input  logic [SLOT_W-1:0]      wait_slot,
    input  logic                   wait_phase,
    output logic [NUM_WAITERS-1:0] wake_o,
    output logic [NUM_SLOTS-1:0]   phase_o,
    output logic [NUM_SLOTS-1:0]   err_o
);
    logic [NUM_SLOTS-1:0] phase_nx;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        txb_slot #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .init_hit   (init_valid && (init_slot == SLOT_W'(s))),
            .init_arr   (init_arrivals),
            .init_bytes (init_bytes),
            .arv_hit    (arv_valid && (arv_slot == SLOT_W'(s))),
            .txb_hit    (txb_valid && (txb_slot == SLOT_W'(s))),
            .txb_bytes  (txb_bytes),
            .phase_o    (phase_o[s]),
            .phase_nx_o (phase_nx[s]),
            .err_o      (err_o[s])
        );
    end

    txb_waiters #(.NW(NUM_WAITERS), .NS(NUM_SLOTS), .SW(SLOT_W), .WID_W(WID_W)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .wait_valid (wait_valid),
        .wait_id    (wait_id),
        .wait_slot  (wait_slot),
        .wait_phase (wait_phase),
        .phase_q    (phase_o),
        .phase_d    (phase_nx),
        .wake_o     (wake_o)
    );

    // R10: at most one slot can flip per cycle when only one slot is addressed
    a_r10_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_valid && !txb_valid && arv_valid) |=> ($countones(phase_o ^ $past(phase_o)) <= 1));
endmodule

// File: tb/tb_txn_barrier.sv
`timescale 1ns/1ps
module tb_txn_barrier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_valid = 1'b0;
    logic [1:0]  init_slot = '0;
    logic [7:0]  init_arrivals = '0;
    logic [15:0] init_bytes = '0;
    logic        arv_valid = 1'b0;
    logic [1:0]  arv_slot = '0;
    logic        txb_valid = 1'b0;
    logic [1:0]  txb_slot = '0;
    logic [15:0] txb_bytes = '0;
    logic        wait_valid = 1'b0;
    logic [1:0]  wait_id = '0;
    logic [1:0]  wait_slot = '0;
    logic        wait_phase = 1'b0;
    logic [3:0]  wake_o, phase_o, err_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] ephase = '0;
    logic [3:0] eerr = '0;

    always #4 clk = ~clk;

    txn_barrier dut (
        .clk(clk), .rst_n(rst_n),
        .init_valid(init_valid), .init_slot(init_slot),
        .init_arrivals(init_arrivals), .init_bytes(init_bytes),
        .arv_valid(arv_valid), .arv_slot(arv_slot),
        .txb_valid(txb_valid), .txb_slot(txb_slot), .txb_bytes(txb_bytes),
        .wait_valid(wait_valid), .wait_id(wait_id), .wait_slot(wait_slot),
        .wait_phase(wait_phase),
        .wake_o(wake_o), .phase_o(phase_o), .err_o(err_o)
    );

    typedef struct packed {
        logic [1:0]  slot;
        logic [7:0]  ea;
        logic [15:0] eb;
        logic [7:0]  na;
        logic [15:0] ch;
        logic [7:0]  nc;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd0, 8'd3, 16'd64, 8'd3, 16'd32, 8'd2},
        '{2'd1, 8'd2, 16'd48, 8'd2, 16'd16, 8'd2},
        '{2'd2, 8'd4, 16'd40, 8'd3, 16'd10, 8'd4},
        '{2'd3, 8'd1, 16'd8,  8'd1, 16'd8,  8'd1},
        '{2'd0, 8'd2, 16'd30, 8'd2, 16'd10, 8'd3},
        '{2'd1, 8'd1, 16'd20, 8'd1, 16'd12, 8'd2},
        '{2'd2, 8'd5, 16'd0,  8'd5, 16'd0,  8'd0},
        '{2'd3, 8'd2, 16'd16, 8'd0, 16'd16, 8'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_init(input logic [1:0] s, input logic [7:0] a, input logic [15:0] b);
        @(negedge clk);
        init_valid = 1'b1; init_slot = s; init_arrivals = a; init_bytes = b;
        @(negedge clk);
        init_valid = 1'b0;
        eerr[s] = 1'b0;
    endtask

    task automatic arrive(input logic [1:0] s);
        arv_valid = 1'b1; arv_slot = s;
        @(negedge clk);
        arv_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 phase", 32'(phase_o), 0);
        check("R1 err", 32'(err_o), 0);
        check("R1 wake", 32'(wake_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 R4 R5 R8 R9 R10
        for (int v = 0; v < 8; v++) begin
            int n;
            logic done;
            logic ov;
            do_init(VEC[v].slot, VEC[v].ea, VEC[v].eb);
            n = (VEC[v].na > VEC[v].nc) ? int'(VEC[v].na) : int'(VEC[v].nc);
            for (int k = 0; k < n; k++) begin
                arv_valid = (k < int'(VEC[v].na)); arv_slot = VEC[v].slot;
                txb_valid = (k < int'(VEC[v].nc)); txb_slot = VEC[v].slot;
                txb_bytes = VEC[v].ch;
                @(negedge clk);
            end
            arv_valid = 1'b0; txb_valid = 1'b0;
            ov   = (32'(VEC[v].ch) * 32'(VEC[v].nc)) > 32'(VEC[v].eb);
            done = !ov && (VEC[v].na == VEC[v].ea) &&
                   ((32'(VEC[v].ch) * 32'(VEC[v].nc)) == 32'(VEC[v].eb));
            ephase[VEC[v].slot] ^= done;
            eerr[VEC[v].slot] = ov;
            check("R4 R5 R9 R10 phases", 32'(phase_o), 32'(ephase));
            check("R8 R10 err flags", 32'(err_o), 32'(eerr));
        end

        // R8: errored slot 1 ignores a further arrival, init clears flag
        arrive(2'd1);
        check("R8 blocked phase", 32'(phase_o[1]), 32'(ephase[1]));
        check("R8 still set", 32'(err_o[1]), 1);
        do_init(2'd1, 8'd1, 16'd0);
        check("R8 cleared by init", 32'(err_o[1]), 0);

        // R6: wait on a phase that already finished wakes in the same cycle
        wait_valid = 1'b1; wait_id = 2'd1; wait_slot = 2'd0; wait_phase = ~ephase[0];
        #1;
        check("R6 immediate wake", 32'(wake_o), 32'b0010);
        @(negedge clk);
        wait_valid = 1'b0;

        // R7: wait on pending phase of slot 1, sleeps then pulses
        wait_valid = 1'b1; wait_id = 2'd2; wait_slot = 2'd1; wait_phase = ephase[1];
        #1;
        check("R7 no early wake", 32'(wake_o), 0);
        @(negedge clk);
        wait_valid = 1'b0;
        @(negedge clk);
        check("R7 still asleep", 32'(wake_o), 0);
        arrive(2'd1);
        ephase[1] ^= 1'b1;
        check("R7 wake pulse", 32'(wake_o), 32'b0100);
        check("R7 phase flip", 32'(phase_o[1]), 32'(ephase[1]));
        @(negedge clk);
        check("R7 pulse ends", 32'(wake_o), 0);

        // R5: same targets reused without init
        arrive(2'd1);
        ephase[1] ^= 1'b1;
        check("R5 reuse flip", 32'(phase_o[1]), 32'(ephase[1]));

        // R3: mid-round init discards gathered arrival
        do_init(2'd2, 8'd2, 16'd0);
        arrive(2'd2);
        do_init(2'd2, 8'd2, 16'd0);
        arrive(2'd2);
        check("R3 discarded count", 32'(phase_o[2]), 32'(ephase[2]));
        // R2: back-to-back arrivals each counted
        do_init(2'd2, 8'd3, 16'd0);
        arrive(2'd2);
        arrive(2'd2);
        check("R2 two of three", 32'(phase_o[2]), 32'(ephase[2]));
        arrive(2'd2);
        ephase[2] ^= 1'b1;
        check("R2 third completes", 32'(phase_o[2]), 32'(ephase[2]));
        check("R10 all phases", 32'(phase_o), 32'(ephase));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule